// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits beside the write controller of a byte-wide nonvolatile memory. It sees every write command (an address and a data byte) and decides whether the controller may store it. It also holds a write-protect flag. Software turns protection on by sending a fixed three-write unlock prefix followed by one real data write. While the flag is on, a data write is stored only when that same prefix comes immediately before it. A separate six-write sequence turns protection off. The flag is a plain register and is cleared by reset.

Every command returns exactly one decision in the cycle after it is presented: either allow or block. Writes that form part of a command sequence are never stored. If a write does not match the next expected step, the matcher drops back to idle and that write is judged as an ordinary data write. Cycles with no command present leave the matcher and the flag unchanged.

Top module: `swp_guard`

## Requirements
- R1: After reset, `prot_on`, `dec_valid`, `dec_allow` and `dec_block` are all 0.
- R2: A command presented with `cmd_valid` high in cycle N gives `dec_valid` high in cycle N+1, with exactly one of `dec_allow` and `dec_block` high. `dec_valid` is low in any cycle that does not follow a command.
- R3: While `prot_on` is 0, an ordinary data write (one that is not a sequence step) is allowed.
- R4: The unlock prefix is address 0x5555 with data 0xAA, then 0x2AAA with 0x55, then 0x5555 with 0xA0. Each of these three writes is blocked, and the prefix on its own leaves `prot_on` unchanged.
- R5: The first write after a complete prefix is allowed, whatever its address and data. Starting with its decision cycle, `prot_on` is 1.
- R6: While `prot_on` is 1, an ordinary data write that is not directly preceded by the prefix is blocked, and `prot_on` stays 1.
- R7: The disable sequence is 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. All six writes are blocked. `prot_on` is 0 from the decision cycle of the last write, and it stays 0 when the sequence is sent while protection is already off.
- R8: A write that differs from the next expected step in any of the 15 address bits or any of the 8 data bits returns the matcher to idle and is judged as an ordinary write under R3 or R6.
- R9: Cycles with `cmd_valid` low neither advance nor reset the matcher. `prot_on` changes only in a decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the protect flag and the matcher |
| cmd_valid | input | 1 | A write command is present this cycle |
| cmd_addr | input | 15 | Write address |
| cmd_data | input | 8 | Write data byte |
| prot_on | output | 1 | Write protection is active |
| dec_valid | output | 1 | A decision for the previous cycle's command is present |
| dec_allow | output | 1 | The write may be stored |
| dec_block | output | 1 | The write must be dropped |

## Verification
Several properties are checked on every cycle at the ports: one decision per command with a fixed latency, no decision without a command, a flag that holds across idle cycles, a rising flag always paired with an allowed write, and a falling flag always paired with a blocked write. Some behaviour depends on the history of the command stream, and only the bench scenarios can show it: that the prefix alone does not enable protection, that a single wrong address or data bit breaks a sequence, that an aborted disable sequence leaves protection on, and that a prefix interrupted by idle cycles still arms the next write.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int CODE_N = 5;

    // index of each command code in the hit vector
    localparam int CI_AA = 0;
    localparam int CI_55 = 1;
    localparam int CI_A0 = 2;
    localparam int CI_80 = 3;
    localparam int CI_20 = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_ARMED,
        ST_X3,
        ST_X4,
        ST_X5
    } seq_st_e;

    typedef enum logic [1:0] {
        CL_PLAIN,
        CL_STEP,
        CL_ARMED_WR,
        CL_UNLOCK
    } cmd_cls_e;

    function automatic logic [15:0] code_addr(input int idx);
        return (idx == CI_55) ? 16'h2AAA : 16'h5555;
    endfunction

    function automatic logic [7:0] code_data(input int idx);
        logic [7:0] v;
        case (idx)
            CI_AA:   v = 8'hAA;
            CI_55:   v = 8'h55;
            CI_A0:   v = 8'hA0;
            CI_80:   v = 8'h80;
            default: v = 8'h20;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/swp_code_match.sv
module swp_code_match
    import swp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [CODE_N-1:0] hit
);

    for (genvar gi = 0; gi < CODE_N; gi++) begin : g_code
        localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(code_addr(gi));
        localparam logic [DATA_W-1:0] KEY_DATA = DATA_W'(code_data(gi));
        assign hit[gi] = (addr == KEY_ADDR) && (data == KEY_DATA);
    end

endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
    import swp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_N-1:0] hit,
    output cmd_cls_e          cls
);

    typedef struct packed {
        seq_st_e st;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        cls   = CL_PLAIN;
        if (cmd_valid) begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (hit[CI_AA]) begin
                        seq_d.st = ST_K1;
                        cls      = CL_STEP;
                    end
                end
                ST_K1: begin
                    if (hit[CI_55]) begin
                        seq_d.st = ST_K2;
                        cls      = CL_STEP;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
                ST_K2: begin
                    if (hit[CI_A0]) begin
                        seq_d.st = ST_ARMED;
                        cls      = CL_STEP;
                    end else if (hit[CI_80]) begin
                        seq_d.st = ST_X3;
                        cls      = CL_STEP;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
                ST_ARMED: begin
                    seq_d.st = ST_IDLE;
                    cls      = CL_ARMED_WR;
                end
                ST_X3: begin
                    if (hit[CI_AA]) begin
                        seq_d.st = ST_X4;
                        cls      = CL_STEP;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
                ST_X4: begin
                    if (hit[CI_55]) begin
                        seq_d.st = ST_X5;
                        cls      = CL_STEP;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
                ST_X5: begin
                    seq_d.st = ST_IDLE;
                    if (hit[CI_20]) begin
                        cls = CL_UNLOCK;
                    end
                end
                default: begin
                    seq_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/swp_wr_decide.sv
module swp_wr_decide
    import swp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  cmd_cls_e cls,
    output logic     prot_on,
    output logic     dec_valid,
    output logic     dec_allow,
    output logic     dec_block
);

    typedef struct packed {
        logic prot;
        logic vld;
        logic allow;
        logic block;
    } dec_regs_t;

    dec_regs_t dec_d, dec_q;

    always_comb begin
        dec_d       = dec_q;
        dec_d.vld   = cmd_valid;
        dec_d.allow = 1'b0;
        dec_d.block = 1'b0;
        if (cmd_valid) begin
            unique case (cls)
                CL_PLAIN: begin
                    dec_d.allow = !dec_q.prot;
                    dec_d.block = dec_q.prot;
                end
                CL_ARMED_WR: begin
                    dec_d.allow = 1'b1;
                    dec_d.prot  = 1'b1;
                end
                CL_UNLOCK: begin
                    dec_d.block = 1'b1;
                    dec_d.prot  = 1'b0;
                end
                default: begin
                    dec_d.block = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign prot_on   = dec_q.prot;
    assign dec_valid = dec_q.vld;
    assign dec_allow = dec_q.allow;
    assign dec_block = dec_q.block;

endmodule

// File: rtl/swp_guard.sv
module swp_guard
    import swp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              prot_on,
    output logic              dec_valid,
    output logic              dec_allow,
    output logic              dec_block
);

    logic [CODE_N-1:0] hit;
    cmd_cls_e          cls;

    swp_code_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_match (
        .addr (cmd_addr),
        .data (cmd_data),
        .hit  (hit)
    );

    swp_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .hit       (hit),
        .cls       (cls)
    );

    swp_wr_decide u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cls       (cls),
        .prot_on   (prot_on),
        .dec_valid (dec_valid),
        .dec_allow (dec_allow),
        .dec_block (dec_block)
    );

endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic prot_on,
    input logic dec_valid,
    input logic dec_allow,
    input logic dec_block
);

    assert_decision_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (dec_valid && (dec_allow != dec_block)));

    assert_no_spurious_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!dec_valid && !dec_allow && !dec_block));

    assert_flag_holds_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(prot_on));

    assert_enable_needs_allow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> (dec_valid && dec_allow));

    assert_disable_is_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> (dec_valid && dec_block));

endmodule

bind swp_guard swp_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .prot_on   (prot_on),
    .dec_valid (dec_valid),
    .dec_allow (dec_allow),
    .dec_block (dec_block)
);

// File: tb/swp_guard_tb.sv
module swp_guard_tb_top;

    localparam logic [14:0] AK = 15'h5555;
    localparam logic [14:0] BK = 15'h2AAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [14:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        prot_on, dec_valid, dec_allow, dec_block;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int    due;
        bit    allow;
        bit    prot;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    swp_guard dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .prot_on   (prot_on),
        .dec_valid (dec_valid),
        .dec_allow (dec_allow),
        .dec_block (dec_block)
    );

    // monitor: compares each decision against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (!dec_valid || dec_allow != e.allow || dec_block == e.allow || prot_on != e.prot) begin
                    bad++;
                    $display("FAIL %s: valid=%0d allow=%0d block=%0d prot=%0d, expected valid=1 allow=%0d block=%0d prot=%0d",
                             e.tag, dec_valid, dec_allow, dec_block, prot_on, e.allow, !e.allow, e.prot);
                end
            end else if (dec_valid) begin
                total++;
                bad++;
                $display("FAIL R2: unexpected decision valid=%0d, expected valid=0", dec_valid);
            end
        end
    end

    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      input bit ea, input bit ep, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_data  = d;
        e.due = cyc + 1;
        e.allow = ea;
        e.prot = ep;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic gap(input int n);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_addr  = '0;
        cmd_data  = '0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_prot(input bit ep, input string tag);
        total++;
        if (prot_on != ep) begin
            bad++;
            $display("FAIL %s: prot_on=%0d expected %0d", tag, prot_on, ep);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (prot_on || dec_valid || dec_allow || dec_block) begin
            bad++;
            $display("FAIL R1: prot=%0d valid=%0d allow=%0d block=%0d expected all 0",
                     prot_on, dec_valid, dec_allow, dec_block);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk_prot(1'b0, "R1");

        // R3: unprotected ordinary writes
        wr(15'h0100, 8'h11, 1, 0, "R3");
        wr(15'h7FFF, 8'hFF, 1, 0, "R3");

        // R4: prefix alone, with idle cycles inside (R9)
        wr(AK, 8'hAA, 0, 0, "R4");
        gap(2);
        wr(BK, 8'h55, 0, 0, "R4");
        wr(AK, 8'hA0, 0, 0, "R4");
        gap(3);
        chk_prot(1'b0, "R4");
        // R5 and R9: armed state survived the gap
        wr(15'h0123, 8'h5A, 1, 1, "R5");

        // R6: plain write under protection
        wr(15'h0200, 8'h22, 0, 1, "R6");
        gap(2);
        chk_prot(1'b1, "R9");

        // R5: prefix plus write under protection, data equal to a code
        wr(AK, 8'hAA, 0, 1, "R4");
        wr(BK, 8'h55, 0, 1, "R4");
        wr(AK, 8'hA0, 0, 1, "R4");
        wr(AK, 8'hAA, 1, 1, "R5");
        wr(15'h0300, 8'h33, 0, 1, "R6");

        // R8: prefix broken by an unrelated write
        wr(AK, 8'hAA, 0, 1, "R4");
        wr(15'h0400, 8'h44, 0, 1, "R8");
        wr(BK, 8'h55, 0, 1, "R8");
        wr(AK, 8'hA0, 0, 1, "R8");
        wr(15'h0410, 8'h45, 0, 1, "R8");

        // R8: one data bit wrong
        wr(AK, 8'hAA, 0, 1, "R4");
        wr(BK, 8'h54, 0, 1, "R8");
        wr(AK, 8'hA0, 0, 1, "R8");
        wr(15'h0500, 8'h55, 0, 1, "R8");

        // R8: one low address bit wrong
        wr(AK, 8'hAA, 0, 1, "R4");
        wr(15'h2AAB, 8'h55, 0, 1, "R8");
        wr(AK, 8'hA0, 0, 1, "R8");
        wr(15'h0600, 8'h66, 0, 1, "R8");

        // R8: top address bit wrong on the first step
        wr(15'h1555, 8'hAA, 0, 1, "R8");
        wr(BK, 8'h55, 0, 1, "R8");
        wr(AK, 8'hA0, 0, 1, "R8");
        wr(15'h0700, 8'h77, 0, 1, "R8");

        // R8: disable sequence broken at the last step
        wr(AK, 8'hAA, 0, 1, "R7");
        wr(BK, 8'h55, 0, 1, "R7");
        wr(AK, 8'h80, 0, 1, "R7");
        wr(AK, 8'hAA, 0, 1, "R7");
        wr(BK, 8'h55, 0, 1, "R7");
        wr(AK, 8'h21, 0, 1, "R8");
        wr(15'h0800, 8'h88, 0, 1, "R8");

        // R7: full disable sequence
        wr(AK, 8'hAA, 0, 1, "R7");
        wr(BK, 8'h55, 0, 1, "R7");
        wr(AK, 8'h80, 0, 1, "R7");
        wr(AK, 8'hAA, 0, 1, "R7");
        wr(BK, 8'h55, 0, 1, "R7");
        wr(AK, 8'h20, 0, 0, "R7");
        wr(15'h0900, 8'h99, 1, 0, "R3");

        // R7: disable sequence while off, with a gap inside
        wr(AK, 8'hAA, 0, 0, "R7");
        wr(BK, 8'h55, 0, 0, "R7");
        gap(2);
        wr(AK, 8'h80, 0, 0, "R7");
        wr(AK, 8'hAA, 0, 0, "R7");
        wr(BK, 8'h55, 0, 0, "R7");
        wr(AK, 8'h20, 0, 0, "R7");
        wr(15'h0A00, 8'hA5, 1, 0, "R3");

        gap(4);
        chk_prot(1'b0, "R7");
        done = 1'b1;
        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R2: %0d decisions missing, expected 0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R2: watchdog expired, expected run to end");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule